// File: doc/BRIEF.md
# Read-Triggered Conversion I2C Target

This block is a two-wire serial target that sits in front of a converter core. A fast system clock samples the serial clock and data lines through synchronisers, and edges and bus conditions are found in that clock domain. A bus master can do two things. It can write a single configuration byte, which the block keeps and presents to the converter. It can also read conversion results. Every read asks for a new conversion, and each result comes back as a two-byte word.

A conversion-start strobe is raised for one system clock. This happens when a read address is acknowledged. It happens again each time the master acknowledges the last byte of a word, which keeps a run of reads going back to back. The word from the converter is captured in the same cycle as the strobe. A result that changes while bytes are going out therefore cannot mix two words.

The block also recognises the high-speed master code. It does not acknowledge that code and waits for the repeated START that follows. The target address is a fixed six-bit prefix, and a strap input supplies the lowest address bit.

Top module: `i2c_conv_target`

## Requirements
- R1: The target acknowledges an address byte whose upper seven bits equal 0101000 or 0101001, with the lowest address bit taken from `addrSel`. The address arrives MSB first, followed by the direction bit (1 = read). Acknowledging means pulling SDA low during the ninth clock.
- R2: After any other address, the target never pulls SDA low until the next START.
- R3: In a write transfer, the target acknowledges the one data byte after the address and drives its value on `cfgOut`.
- R4: Any byte after the first data byte of a write is not acknowledged, and `cfgOut` keeps its value.
- R5: A read returns the 16-bit result word MSB first, high byte first. SDA is only taken low after a falling SCL edge.
- R6: `convStart` pulses for exactly one clock when the read-address acknowledge clock ends. A write transfer produces no pulse.
- R7: If the master acknowledges the second byte of a word, a new conversion starts and a fresh word follows. A master NACK ends the read with no further pulse and SDA released.
- R8: The word returned is the `resultIn` value present when the start pulse is issued. Later changes to `resultIn` do not affect the bytes of that word.
- R9: A master code of the form 00001xxx is not acknowledged. A repeated START that follows it begins a normal addressed transfer.
- R10: A STOP releases SDA and returns the target to idle. A START at any point restarts address reception, and a partly received data byte is discarded.
- R11: After reset, SDA is released, `cfgOut` equals the reset value (0x00), and `convStart` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Serial clock line as seen at the pin |
| sdaIn | input | 1 | Serial data line as seen at the pin |
| sdaPull | output | 1 | 1 = pull SDA low |
| addrSel | input | 1 | Strap supplying the lowest address bit |
| cfgOut | output | 8 | Stored configuration byte |
| convStart | output | 1 | One-cycle request to start a conversion |
| resultIn | input | 16 | Most recent result word from the converter |

## Verification
Assertions are checked on every clock for the following:
- the conversion request is a single-cycle pulse, and it only follows an acknowledge clock in the read path;
- SDA is never pulled while the target ignores the bus or sits idle;
- a STOP always releases SDA;
- a new pull-down only begins after a falling SCL edge;
- the configuration byte only changes when a write data byte is acknowledged.

Only the bench's transfer scenarios can show the following:
- the returned byte order and bit order;
- that the word cannot be torn when `resultIn` changes mid-read;
- that continued reads start fresh conversions;
- that the master code is refused and a repeated START is then accepted;
- that extra write bytes and address mismatches leave the configuration unchanged.

// File: rtl/i2c_conv_pkg.sv
`timescale 1ns/1ps
package i2c_conv_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR_DATA,
    ST_WR_ACK, ST_RD_BYTE, ST_RD_ACK, ST_IGNORE
  } busState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;
    logic bitTick;
    logic setPull;
    logic clrPull;
    logic txLoad;
    logic txShift;
    logic cfgLoad;
    logic convPulse;
  } dpCmd_t;

  // events from datapath to control
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startDet;
    logic stopDet;
    logic byteDone;
  } busEv_t;
endpackage

// File: rtl/i2c_conv_dp.sv
`timescale 1ns/1ps
module i2c_conv_dp
  import i2c_conv_pkg::*;
#(
  parameter int          RES_BYTES   = 2,
  parameter int          SYNC_STAGES = 2,
  parameter logic [7:0]  CFG_RESET   = 8'h00
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        sclIn,
  input  logic                        sdaIn,
  input  dpCmd_t                      cmd,
  input  logic [RES_BYTES*BYTE_W-1:0] resultIn,
  output busEv_t                      ev,
  output logic [BYTE_W-1:0]           rxByte,
  output logic                        sdaPull,
  output logic [BYTE_W-1:0]           cfgOut,
  output logic                        convStart
);
  localparam int RES_W = RES_BYTES * BYTE_W;

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclS, sdaS, sclD, sdaD;

  // synchroniser chains, idle bus is high
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) begin
          sclPipe <= '1;
          sdaPipe <= '1;
        end else begin
          sclPipe <= sclIn;
          sdaPipe <= sdaIn;
        end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) begin
          sclPipe <= '1;
          sdaPipe <= '1;
        end else begin
          sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
          sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
        end
    end
  endgenerate

  assign sclS = sclPipe[SYNC_STAGES-1];
  assign sdaS = sdaPipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclD <= sclS;
      sdaD <= sdaS;
    end

  logic [CNT_W-1:0]  bitCnt;
  logic [BYTE_W-1:0] rxReg;
  logic [RES_W-1:0]  txReg;
  logic              pullQ, convQ;
  logic [BYTE_W-1:0] cfgQ;

  assign ev.sclRise  = sclS & ~sclD;
  assign ev.sclFall  = ~sclS & sclD;
  assign ev.startDet = sclS & sclD & sdaD & ~sdaS;
  assign ev.stopDet  = sclS & sclD & ~sdaD & sdaS;
  assign ev.byteDone = (bitCnt == CNT_W'(BYTE_W));

  // receive shifter and bit counter
  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      bitCnt <= '0;
      rxReg  <= '0;
    end else if (cmd.cntClr) begin
      bitCnt <= '0;
    end else if (cmd.bitTick) begin
      bitCnt <= bitCnt + 1'b1;
      rxReg  <= {rxReg[BYTE_W-2:0], sdaS};
    end

  // transmit shifter: word captured once per conversion request
  always_ff @(posedge clk or negedge rstN)
    if (!rstN)             txReg <= '0;
    else if (cmd.txLoad)   txReg <= resultIn;
    else if (cmd.txShift)  txReg <= {txReg[RES_W-2:0], 1'b0};

  // SDA pull-down register
  always_ff @(posedge clk or negedge rstN)
    if (!rstN)             pullQ <= 1'b0;
    else if (cmd.clrPull)  pullQ <= 1'b0;
    else if (cmd.setPull)  pullQ <= 1'b1;
    else if (cmd.txLoad)   pullQ <= ~resultIn[RES_W-1];
    else if (cmd.txShift)  pullQ <= ~txReg[RES_W-2];

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)             cfgQ <= CFG_RESET;
    else if (cmd.cfgLoad)  cfgQ <= rxReg;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) convQ <= 1'b0;
    else       convQ <= cmd.convPulse;

  assign rxByte    = rxReg;
  assign sdaPull   = pullQ;
  assign cfgOut    = cfgQ;
  assign convStart = convQ;

  // R6
  conv_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    convQ |=> !convQ);
  // R10
  stop_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    ev.stopDet |=> !pullQ);
  // R5
  pull_after_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pullQ) |-> $past(ev.sclFall));
endmodule

// File: rtl/i2c_conv_ctrl.sv
`timescale 1ns/1ps
module i2c_conv_ctrl
  import i2c_conv_pkg::*;
#(
  parameter logic [6:0] ADDR_BASE = 7'h28,
  parameter int         RES_BYTES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  busEv_t            ev,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              addrSel,
  output dpCmd_t            cmd,
  output busState_e         state
);
  localparam int IDX_W = (RES_BYTES > 1) ? $clog2(RES_BYTES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(RES_BYTES - 1);

  busState_e      stateQ, nxt;
  logic [IDX_W-1:0] byteIdx, nxtIdx;
  logic           addrHit, masterAck;

  // the master code 00001xxx can never equal the address, so it lands in ST_IGNORE
  assign addrHit   = (rxByte[7:1] == {ADDR_BASE[6:1], addrSel});
  assign masterAck = ~rxByte[0];

  always_comb begin
    cmd    = '0;
    nxt    = stateQ;
    nxtIdx = byteIdx;
    if (ev.stopDet) begin
      cmd.clrPull = 1'b1;
      nxt         = ST_IDLE;
    end else if (ev.startDet) begin
      cmd.clrPull = 1'b1;
      cmd.cntClr  = 1'b1;
      nxt         = ST_ADDR;
    end else begin
      unique case (stateQ)
        ST_ADDR: begin
          if (ev.sclRise) cmd.bitTick = 1'b1;
          else if (ev.sclFall && ev.byteDone) begin
            if (addrHit) begin
              cmd.setPull = 1'b1;
              nxt         = ST_ADDR_ACK;
            end else begin
              nxt = ST_IGNORE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (ev.sclFall) begin
            cmd.cntClr = 1'b1;
            if (rxByte[0]) begin
              cmd.txLoad    = 1'b1;
              cmd.convPulse = 1'b1;
              nxtIdx        = '0;
              nxt           = ST_RD_BYTE;
            end else begin
              cmd.clrPull = 1'b1;
              nxt         = ST_WR_DATA;
            end
          end
        end
        ST_WR_DATA: begin
          if (ev.sclRise) cmd.bitTick = 1'b1;
          else if (ev.sclFall && ev.byteDone) begin
            cmd.cfgLoad = 1'b1;
            cmd.setPull = 1'b1;
            nxt         = ST_WR_ACK;
          end
        end
        ST_WR_ACK: begin
          if (ev.sclFall) begin
            cmd.clrPull = 1'b1;
            nxt         = ST_IGNORE;
          end
        end
        ST_RD_BYTE: begin
          if (ev.sclRise) cmd.bitTick = 1'b1;
          else if (ev.sclFall) begin
            if (ev.byteDone) begin
              cmd.clrPull = 1'b1;
              cmd.cntClr  = 1'b1;
              nxt         = ST_RD_ACK;
            end else begin
              cmd.txShift = 1'b1;
            end
          end
        end
        ST_RD_ACK: begin
          if (ev.sclRise) cmd.bitTick = 1'b1;
          else if (ev.sclFall) begin
            cmd.cntClr = 1'b1;
            if (!masterAck) begin
              nxt = ST_IGNORE;
            end else if (byteIdx != LAST_IDX) begin
              cmd.txShift = 1'b1;
              nxtIdx      = IDX_W'(byteIdx + 1'b1);
              nxt         = ST_RD_BYTE;
            end else begin
              cmd.txLoad    = 1'b1;
              cmd.convPulse = 1'b1;
              nxtIdx        = '0;
              nxt           = ST_RD_BYTE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      byteIdx <= '0;
    end else begin
      stateQ  <= nxt;
      byteIdx <= nxtIdx;
    end

  assign state = stateQ;

  // R1
  ack_after_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_ADDR_ACK) |-> $past(stateQ == ST_ADDR || stateQ == ST_ADDR_ACK));
endmodule

// File: rtl/i2c_conv_target.sv
`timescale 1ns/1ps
module i2c_conv_target
  import i2c_conv_pkg::*;
#(
  parameter logic [6:0] ADDR_BASE   = 7'h28,
  parameter int         RES_BYTES   = 2,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] CFG_RESET   = 8'h00
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        sclIn,
  input  logic                        sdaIn,
  output logic                        sdaPull,
  input  logic                        addrSel,
  output logic [7:0]                  cfgOut,
  output logic                        convStart,
  input  logic [RES_BYTES*BYTE_W-1:0] resultIn
);
  dpCmd_t            cmd;
  busEv_t            ev;
  logic [BYTE_W-1:0] rxByte;
  busState_e         state;

  i2c_conv_ctrl #(.ADDR_BASE(ADDR_BASE), .RES_BYTES(RES_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .ev(ev), .rxByte(rxByte),
    .addrSel(addrSel), .cmd(cmd), .state(state)
  );

  i2c_conv_dp #(.RES_BYTES(RES_BYTES), .SYNC_STAGES(SYNC_STAGES),
                .CFG_RESET(CFG_RESET)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .cmd(cmd),
    .resultIn(resultIn), .ev(ev), .rxByte(rxByte), .sdaPull(sdaPull),
    .cfgOut(cfgOut), .convStart(convStart)
  );

  // R2
  ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IGNORE) |-> !sdaPull);
  // R4
  cfg_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cfgOut) |-> (state == ST_WR_ACK));
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> (!sdaPull && !convStart));
  // R6
  conv_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> $past(state == ST_ADDR_ACK || state == ST_RD_ACK));
endmodule

// File: tb/i2c_conv_target_tb.sv
`timescale 1ns/1ps
module i2c_conv_target_tb;
  localparam int Q = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic addrSel = 1'b0;
  logic [15:0] resultIn = 16'h0000;
  logic sdaPull, convStart;
  logic [7:0] cfgOut;
  logic sdaLine;

  int checks = 0, errors = 0, cyc = 0, convCount = 0;
  bit pullSeen = 1'b0;
  logic [7:0] cfgModel = 8'h00;

  always #4 clk = ~clk;
  assign sdaLine = sdaM & ~sdaPull;

  i2c_conv_target u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .sdaPull(sdaPull),
    .addrSel(addrSel), .cfgOut(cfgOut), .convStart(convStart), .resultIn(resultIn)
  );

  always @(posedge clk) begin
    if (convStart) convCount++;
    if (sdaPull) pullSeen = 1'b1;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic waitClk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic checkEq(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sendBit(input logic b);
    sdaM = b; waitClk(Q);
    sclM = 1'b1; waitClk(2*Q);
    sclM = 1'b0; waitClk(Q);
  endtask

  task automatic recvBit(output logic b);
    sdaM = 1'b1; waitClk(Q);
    sclM = 1'b1; waitClk(Q);
    b = sdaLine; waitClk(Q);
    sclM = 1'b0; waitClk(Q);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitClk(Q);
    sclM = 1'b1; waitClk(Q);
    sdaM = 1'b0; waitClk(Q);
    sclM = 1'b0; waitClk(Q);
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitClk(Q);
    sclM = 1'b1; waitClk(Q);
    sdaM = 1'b1; waitClk(Q);
  endtask

  task automatic sendByte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    recvBit(b);
    ack = ~b;
  endtask

  task automatic recvByte(input logic mAck, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recvBit(b);
      v[i] = b;
    end
    sendBit(~mAck);
  endtask

  // {strap, address, data, expected ack}
  localparam logic [16:0] WR_VEC [7] = '{
    {1'b0, 7'h28, 8'hA5, 1'b1},
    {1'b1, 7'h29, 8'h3C, 1'b1},
    {1'b0, 7'h29, 8'h77, 1'b0},
    {1'b1, 7'h28, 8'h11, 1'b0},
    {1'b0, 7'h28, 8'h00, 1'b1},
    {1'b1, 7'h29, 8'hFF, 1'b1},
    {1'b0, 7'h50, 8'h12, 1'b0}
  };

  initial begin
    logic ack;
    logic [7:0] rb;
    int c0;

    waitClk(5);
    // R11 reset state
    checkEq("R11 sdaPull in reset", 16'(sdaPull), 16'h0);
    checkEq("R11 cfgOut in reset", 16'(cfgOut), 16'h00);
    checkEq("R11 convStart in reset", 16'(convStart), 16'h0);
    rstN = 1'b1;
    waitClk(10);
    checkEq("R11 sdaPull after reset", 16'(sdaPull), 16'h0);

    // table of write transfers: R1 R2 R3 R6
    for (int k = 0; k < 7; k++) begin
      logic [16:0] v;
      v = WR_VEC[k];
      addrSel = v[16];
      waitClk(4);
      c0 = convCount;
      pullSeen = 1'b0;
      busStart();
      sendByte({v[15:9], 1'b0}, ack);
      checkEq("R1 address ack", 16'(ack), 16'(v[0]));
      sendByte(v[8:1], ack);
      checkEq("R3 data ack", 16'(ack), 16'(v[0]));
      busStop();
      waitClk(8);
      if (v[0]) cfgModel = v[8:1];
      checkEq("R3 cfgOut after write", 16'(cfgOut), 16'(cfgModel));
      checkEq("R6 no pulse on write", 16'(convCount - c0), 16'h0);
      if (!v[0]) checkEq("R2 SDA untouched on mismatch", 16'(pullSeen), 16'h0);
      checkEq("R10 SDA released after stop", 16'(sdaPull), 16'h0);
    end

    // basic read, tearing attempt, NACK end: R5 R6 R7 R8
    addrSel = 1'b0;
    resultIn = 16'hC3A5;
    c0 = convCount;
    busStart();
    sendByte(8'h51, ack);
    checkEq("R1 read address ack", 16'(ack), 16'h1);
    checkEq("R6 one pulse after read address", 16'(convCount - c0), 16'h1);
    resultIn = 16'h0F0F;
    recvByte(1'b1, rb);
    checkEq("R5 high byte", 16'(rb), 16'h00C3);
    recvByte(1'b0, rb);
    checkEq("R8 low byte from captured word", 16'(rb), 16'h00A5);
    checkEq("R7 no pulse after NACK", 16'(convCount - c0), 16'h1);
    checkEq("R7 SDA released after NACK", 16'(sdaPull), 16'h0);
    busStop();

    // continued read: R7 R8
    resultIn = 16'h1234;
    c0 = convCount;
    busStart();
    sendByte(8'h51, ack);
    recvByte(1'b1, rb);
    checkEq("R5 word1 high", 16'(rb), 16'h0012);
    resultIn = 16'hBEEF;
    recvByte(1'b1, rb);
    checkEq("R8 word1 low", 16'(rb), 16'h0034);
    checkEq("R7 second pulse after master ACK", 16'(convCount - c0), 16'h2);
    recvByte(1'b1, rb);
    checkEq("R7 word2 high", 16'(rb), 16'h00BE);
    recvByte(1'b0, rb);
    checkEq("R7 word2 low", 16'(rb), 16'h00EF);
    busStop();
    waitClk(8);
    checkEq("R7 pulse count after NACK", 16'(convCount - c0), 16'h2);

    // extra write byte: R4
    busStart();
    sendByte(8'h50, ack);
    sendByte(8'h5A, ack);
    checkEq("R3 first data byte ack", 16'(ack), 16'h1);
    sendByte(8'h99, ack);
    checkEq("R4 extra byte not acked", 16'(ack), 16'h0);
    busStop();
    waitClk(8);
    checkEq("R4 cfgOut keeps first byte", 16'(cfgOut), 16'h005A);

    // master code then repeated START: R9
    addrSel = 1'b1;
    resultIn = 16'h6C81;
    pullSeen = 1'b0;
    busStart();
    sendByte(8'h0B, ack);
    checkEq("R9 master code not acked", 16'(ack), 16'h0);
    checkEq("R9 SDA untouched on master code", 16'(pullSeen), 16'h0);
    busStart();
    sendByte(8'h53, ack);
    checkEq("R9 address after repeated start", 16'(ack), 16'h1);
    recvByte(1'b1, rb);
    checkEq("R9 high byte", 16'(rb), 16'h006C);
    recvByte(1'b0, rb);
    checkEq("R9 low byte", 16'(rb), 16'h0081);
    busStop();

    // START inside a data byte: R10
    busStart();
    sendByte(8'h52, ack);
    checkEq("R10 write address ack", 16'(ack), 16'h1);
    for (int i = 0; i < 4; i++) sendBit(1'b0);
    resultIn = 16'h7E01;
    busStart();
    sendByte(8'h53, ack);
    checkEq("R10 restart address ack", 16'(ack), 16'h1);
    recvByte(1'b1, rb);
    checkEq("R10 read after restart high", 16'(rb), 16'h007E);
    recvByte(1'b0, rb);
    checkEq("R10 read after restart low", 16'(rb), 16'h0001);
    busStop();
    waitClk(8);
    checkEq("R10 partial byte discarded", 16'(cfgOut), 16'h005A);
    checkEq("R10 SDA released at end", 16'(sdaPull), 16'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule